// File: doc/BRIEF.md
# Platform Sleep State Controller

This block keeps track of which power state a platform is in: fully on (S0), suspend-to-disk (S4), soft-off (S5) or a no-power condition (G3). From that state it drives two active-low sleep outputs that the board uses to switch its power rails. Software asks for sleep by placing a sleep type on `sw_slp_typ` and pulsing `sw_slp_go`. Four hardware sources force soft-off from the on state: a power button held past a timeout, a thermal trip, a shutdown request from a manageability agent, and an internal watchdog timeout.

Enabled wake sources bring the platform from S4 or S5 back to S0 and set a sticky wake flag, which software clears by writing one. When main power drops, the controller enters G3 and remembers the state it left. When power comes back, it picks the resume state from a policy bit, but only while the battery-low input is inactive. A slow real-time clock enable times the button hold, so the override works without any other clock source.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While reset is asserted, `pwr_state` reads G3 (3), both sleep outputs are low, and `wake_sts` is 0. Reset also sets the remembered state to S5.
- R2: In S0 with no forced source active, a `sw_slp_go` pulse with `sw_slp_typ` = 6 moves the state to S4 (code 1) on the next edge, and with 7 moves it to S5 (code 2). Any other type code leaves the state at S0. A request made in S4 or S5 is ignored.
- R3: In S0, `therm_trip` moves the state to S5 on the next edge.
- R4: In S0, `mgmt_shutdown` or `wdt_timeout` moves the state to S5 on the next edge.
- R5: Holding `pwr_btn_n` low through `BTN_TICKS` pulses of `rtc_tick` forces S0 to S5. Releasing the button restarts the count, so two holds that are each one pulse short never trigger the override.
- R6: A forced source that arrives in the same cycle as a software request wins, and the state goes to S5.
- R7: In S0 both sleep outputs are high. In S4 only `slp_s4_n` is low. In S5 and G3 both outputs are low.
- R8: In S4 or S5, any `wake_req` bit whose matching `wake_en` bit is set moves the state to S0 on the next edge and sets `wake_sts`. Wake bits that are not enabled have no effect.
- R9: `wake_sts` stays set until a `wake_sts_clr` pulse. If a wake and a clear happen in the same cycle, the flag is set.
- R10: When `power_good` is low, the state becomes G3 on the next edge, and the state it left is remembered.
- R11: When power returns and `resume_off` is set, the state goes to S4 if S4 was remembered and to S5 otherwise. When `resume_off` is clear, the state goes to S0.
- R12: While `batt_low` is high, the state stays in G3 even with `power_good` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable at the RTC rate (32.768 kHz) |
| sw_slp_typ | input | 3 | Requested sleep type (6 = S4, 7 = S5) |
| sw_slp_go | input | 1 | Software sleep-entry strobe |
| pwr_btn_n | input | 1 | Power button, low while pressed |
| therm_trip | input | 1 | Thermal trip request |
| mgmt_shutdown | input | 1 | Manageability shutdown request |
| wdt_timeout | input | 1 | Watchdog timeout event |
| wake_req | input | NUM_WAKE | Wake event lines |
| wake_en | input | NUM_WAKE | Per-line wake enables |
| wake_sts_clr | input | 1 | Write-one-to-clear strobe for the wake flag |
| power_good | input | 1 | Main power present |
| batt_low | input | 1 | Battery low; blocks resume from G3 |
| resume_off | input | 1 | Resume policy after power loss |
| pwr_state | output | 2 | Current state: 0 = S0, 1 = S4, 2 = S5, 3 = G3 |
| slp_s4_n | output | 1 | Active-low S4 sleep output |
| slp_s5_n | output | 1 | Active-low S5 sleep output |
| wake_sts | output | 1 | Sticky wake status flag |

## Verification
The bench presses the button for one RTC pulse less than the threshold, releases it, and presses again. A counter that does not clear on release would reach the threshold across the two holds and shut the platform down early. It sends a forced source together with a software S4 request: a design that ranks the request higher would stop in S4 instead of S5. It tries each resume path from G3. A design that ignores the remembered state would wrongly restore S4 after a loss in S0, and a design that ignores `batt_low` would leave G3 with a weak battery. It also pulses a wake and a clear in the same cycle, where a design that ranks the clear higher would lose the wake.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
    typedef enum logic [1:0] {
        PS_S0 = 2'd0,
        PS_S4 = 2'd1,
        PS_S5 = 2'd2,
        PS_G3 = 2'd3
    } pstate_e;

    localparam logic [2:0] SLPTYP_S4 = 3'd6;
    localparam logic [2:0] SLPTYP_S5 = 3'd7;

    typedef struct packed {
        pstate_e state;
        pstate_e held;
        logic    wake_sts;
    } ctrl_regs_t;
endpackage

// File: rtl/pss_btn_timer.sv
module pss_btn_timer #(
    parameter int BTN_TICKS = 131072,
    localparam int CW = $clog2(BTN_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rtc_tick,
    input  logic btn_held,
    output logic fire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } btn_regs_t;

    btn_regs_t q, d;

    // Count RTC pulses while the button is held; fire once on reaching the limit.
    always_comb begin
        d      = q;
        d.fire = 1'b0;
        if (!btn_held) begin
            d.cnt = '0;
        end else if (rtc_tick && q.cnt != CW'(BTN_TICKS)) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(BTN_TICKS - 1)) d.fire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire = q.fire;
endmodule

// File: rtl/pss_entry_decode.sv
module pss_entry_decode
    import pwr_state_pkg::*;
(
    input  logic [2:0] slp_typ,
    input  logic       slp_go,
    input  logic       therm_trip,
    input  logic       mgmt_shutdown,
    input  logic       wdt_timeout,
    input  logic       btn_fire,
    output logic       force_off,
    output logic       req_valid,
    output pstate_e    req_state
);
    always_comb begin
        force_off = therm_trip | mgmt_shutdown | wdt_timeout | btn_fire;
        req_valid = 1'b0;
        req_state = PS_S0;
        if (slp_go) begin
            unique case (slp_typ)
                SLPTYP_S4: begin req_valid = 1'b1; req_state = PS_S4; end
                SLPTYP_S5: begin req_valid = 1'b1; req_state = PS_S5; end
                default:   begin req_valid = 1'b0; req_state = PS_S0; end
            endcase
        end
    end
endmodule

// File: rtl/pss_resume_sel.sv
module pss_resume_sel
    import pwr_state_pkg::*;
(
    input  pstate_e held,
    input  logic    resume_off,
    output pstate_e target
);
    always_comb begin
        if (!resume_off)          target = PS_S0;
        else if (held == PS_S4)   target = PS_S4;
        else                      target = PS_S5;
    end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int NUM_WAKE  = 4,
    parameter int BTN_TICKS = 131072
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rtc_tick,
    input  logic [2:0]          sw_slp_typ,
    input  logic                sw_slp_go,
    input  logic                pwr_btn_n,
    input  logic                therm_trip,
    input  logic                mgmt_shutdown,
    input  logic                wdt_timeout,
    input  logic [NUM_WAKE-1:0] wake_req,
    input  logic [NUM_WAKE-1:0] wake_en,
    input  logic                wake_sts_clr,
    input  logic                power_good,
    input  logic                batt_low,
    input  logic                resume_off,
    output logic [1:0]          pwr_state,
    output logic                slp_s4_n,
    output logic                slp_s5_n,
    output logic                wake_sts
);
    ctrl_regs_t q, d;
    logic    btn_fire;
    logic    force_off, req_valid, wake_hit, asleep;
    pstate_e req_state, resume_tgt;

    pss_btn_timer #(.BTN_TICKS(BTN_TICKS)) u_btn (
        .clk      (clk),
        .rst_n    (rst_n),
        .rtc_tick (rtc_tick),
        .btn_held (~pwr_btn_n),
        .fire     (btn_fire)
    );

    pss_entry_decode u_dec (
        .slp_typ       (sw_slp_typ),
        .slp_go        (sw_slp_go),
        .therm_trip    (therm_trip),
        .mgmt_shutdown (mgmt_shutdown),
        .wdt_timeout   (wdt_timeout),
        .btn_fire      (btn_fire),
        .force_off     (force_off),
        .req_valid     (req_valid),
        .req_state     (req_state)
    );

    pss_resume_sel u_res (
        .held       (q.held),
        .resume_off (resume_off),
        .target     (resume_tgt)
    );

    assign wake_hit = |(wake_req & wake_en);
    assign asleep   = (q.state == PS_S4) || (q.state == PS_S5);

    always_comb begin
        d = q;
        if (!power_good) begin
            if (q.state != PS_G3) d.held = q.state;
            d.state = PS_G3;
        end else begin
            unique case (q.state)
                PS_G3: if (!batt_low) d.state = resume_tgt;
                PS_S0: begin
                    if (force_off)      d.state = PS_S5;
                    else if (req_valid) d.state = req_state;
                end
                default: if (wake_hit) d.state = PS_S0;
            endcase
        end
        d.wake_sts = (power_good && asleep && wake_hit) | (q.wake_sts & ~wake_sts_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= PS_G3;
            q.held     <= PS_S5;
            q.wake_sts <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pwr_state = q.state;
    assign slp_s4_n  = (q.state == PS_S0);
    assign slp_s5_n  = (q.state == PS_S0) || (q.state == PS_S4);
    assign wake_sts  = q.wake_sts;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
    parameter int NUM_WAKE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          sw_slp_typ,
    input logic                sw_slp_go,
    input logic                therm_trip,
    input logic                mgmt_shutdown,
    input logic                wdt_timeout,
    input logic                btn_fire,
    input logic [NUM_WAKE-1:0] wake_req,
    input logic [NUM_WAKE-1:0] wake_en,
    input logic                wake_sts_clr,
    input logic                power_good,
    input logic                batt_low,
    input logic [1:0]          pwr_state,
    input logic                slp_s4_n,
    input logic                slp_s5_n,
    input logic                wake_sts
);
    logic forced, woke, bad_typ;
    assign forced  = therm_trip | mgmt_shutdown | wdt_timeout | btn_fire;
    assign woke    = (pwr_state == 2'd1 || pwr_state == 2'd2) && |(wake_req & wake_en) && power_good;
    assign bad_typ = sw_slp_typ != 3'd6 && sw_slp_typ != 3'd7;

    a_r2_bad_type_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && power_good && sw_slp_go && bad_typ && !forced) |=> pwr_state == 2'd0);

    a_r3_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && power_good && therm_trip) |=> pwr_state == 2'd2);

    a_r6_forced_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && power_good && forced && sw_slp_go) |=> pwr_state == 2'd2);

    a_r7_s5_implies_s4: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_s5_n |-> !slp_s4_n);

    a_r8_wake_to_s0: assert property (@(posedge clk) disable iff (!rst_n)
        woke |=> (pwr_state == 2'd0 && wake_sts));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sts && !wake_sts_clr) |=> wake_sts);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sts_clr && !woke) |=> !wake_sts);

    a_r10_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> pwr_state == 2'd3);

    a_r12_batt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && batt_low) |=> pwr_state == 2'd3);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (.*);

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 4;
    localparam int TICKS      = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rtc_tick = 1'b0;
    logic [2:0]    sw_slp_typ = 3'd0;
    logic          sw_slp_go = 1'b0;
    logic          pwr_btn_n = 1'b1;
    logic          therm_trip = 1'b0, mgmt_shutdown = 1'b0, wdt_timeout = 1'b0;
    logic [NW-1:0] wake_req = '0;
    logic [NW-1:0] wake_en = '1;
    logic          wake_sts_clr = 1'b0;
    logic          power_good = 1'b1, batt_low = 1'b0, resume_off = 1'b0;
    logic [1:0]    pwr_state;
    logic          slp_s4_n, slp_s5_n, wake_sts;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_state_ctrl #(.NUM_WAKE(NW), .BTN_TICKS(TICKS)) u_pwr_state_ctrl (.*);

    // Vector: {go, typ[2:0], therm, mgmt, wdt, exp_state[1:0]}, applied from S0.
    localparam logic [8:0] VEC [9] = '{
        {1'b1, 3'd6, 3'b000, 2'd1},  // R2 S4 entry
        {1'b1, 3'd7, 3'b000, 2'd2},  // R2 S5 entry
        {1'b1, 3'd3, 3'b000, 2'd0},  // R2 unsupported type ignored
        {1'b1, 3'd0, 3'b000, 2'd0},  // R2 unsupported type ignored
        {1'b0, 3'd0, 3'b100, 2'd2},  // R3 thermal trip
        {1'b0, 3'd0, 3'b010, 2'd2},  // R4 manageability shutdown
        {1'b0, 3'd0, 3'b001, 2'd2},  // R4 watchdog timeout
        {1'b1, 3'd6, 3'b100, 2'd2},  // R6 thermal beats S4 request
        {1'b1, 3'd6, 3'b001, 2'd2}   // R6 watchdog beats S4 request
    };
    localparam string VREQ [9] = '{"R2", "R2", "R2", "R2", "R3", "R4", "R4", "R6", "R6"};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R7 output encoding per state.
    task automatic chk_state(input string req, input int exp);
        chk(req, pwr_state, exp);
        chk("R7 slp_s4_n", slp_s4_n, (exp == 0) ? 1 : 0);
        chk("R7 slp_s5_n", slp_s5_n, (exp <= 1) ? 1 : 0);
    endtask

    task automatic wake_pulse(input int idx);
        @(negedge clk) wake_req = NW'(1) << idx;
        @(negedge clk) wake_req = '0;
    endtask

    task automatic clear_sts();
        @(negedge clk) wake_sts_clr = 1'b1;
        @(negedge clk) wake_sts_clr = 1'b0;
    endtask

    task automatic to_s0();
        if (pwr_state != 2'd0) begin
            wake_pulse(0);
            clear_sts();
        end
    endtask

    task automatic rtc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
        end
    endtask

    task automatic lose_and_restore(input logic policy);
        @(negedge clk) power_good = 1'b0;
        @(negedge clk);
        chk_state("R10 enters G3", 3);
        resume_off = policy;
        power_good = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        #(CLK_PERIOD * 3);
        chk_state("R1 reset state", 3);
        chk("R1 wake_sts", wake_sts, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk_state("R11 resume policy clear to S0", 0);

        for (int v = 0; v < 9; v++) begin
            to_s0();
            @(negedge clk);
            {sw_slp_go, sw_slp_typ, therm_trip, mgmt_shutdown, wdt_timeout} = VEC[v][8:2];
            @(negedge clk);
            {sw_slp_go, sw_slp_typ, therm_trip, mgmt_shutdown, wdt_timeout} = '0;
            chk_state(VREQ[v], int'(VEC[v][1:0]));
        end

        // R2 request outside S0 ignored; R8 disabled wake ignored
        to_s0();
        @(negedge clk) begin sw_slp_go = 1'b1; sw_slp_typ = 3'd6; end
        @(negedge clk) begin sw_slp_typ = 3'd7; end
        @(negedge clk) sw_slp_go = 1'b0;
        chk_state("R2 request in S4 ignored", 1);
        wake_en = 4'b1101;
        wake_pulse(1);
        chk_state("R8 disabled wake ignored", 1);
        chk("R8 wake_sts stays clear", wake_sts, 0);
        wake_pulse(2);
        chk_state("R8 enabled wake to S0", 0);
        chk("R8 wake_sts set", wake_sts, 1);
        wake_en = '1;
        @(negedge clk);
        chk("R9 wake_sts sticky", wake_sts, 1);
        clear_sts();
        chk("R9 cleared by strobe", wake_sts, 0);

        // R9 set beats clear
        @(negedge clk) begin therm_trip = 1'b1; end
        @(negedge clk) begin therm_trip = 1'b0; wake_req = 4'b0001; wake_sts_clr = 1'b1; end
        @(negedge clk) begin wake_req = '0; wake_sts_clr = 1'b0; end
        chk("R9 set wins over clear", wake_sts, 1);
        chk_state("R8 wake from S5", 0);
        clear_sts();

        // R5 button override
        @(negedge clk) pwr_btn_n = 1'b0;
        rtc_pulses(TICKS - 1);
        @(negedge clk) pwr_btn_n = 1'b1;
        @(negedge clk) pwr_btn_n = 1'b0;
        rtc_pulses(TICKS - 1);
        repeat (3) @(negedge clk);
        chk_state("R5 short holds do not accumulate", 0);
        rtc_pulses(1);
        @(negedge clk);
        chk_state("R5 override to S5", 2);
        pwr_btn_n = 1'b1;

        // R10 / R11 resume policy
        to_s0();
        @(negedge clk) begin sw_slp_go = 1'b1; sw_slp_typ = 3'd6; end
        @(negedge clk) sw_slp_go = 1'b0;
        lose_and_restore(1'b1);
        chk_state("R11 S4 restored", 1);
        to_s0();
        lose_and_restore(1'b1);
        chk_state("R11 S0 to S5", 2);
        lose_and_restore(1'b1);
        chk_state("R11 S5 stays S5", 2);
        wake_pulse(0);
        clear_sts();
        @(negedge clk) begin sw_slp_go = 1'b1; sw_slp_typ = 3'd6; end
        @(negedge clk) sw_slp_go = 1'b0;
        lose_and_restore(1'b0);
        chk_state("R11 policy clear from S4", 0);

        // R12 battery low holds G3
        @(negedge clk) begin power_good = 1'b0; batt_low = 1'b1; end
        @(negedge clk) power_good = 1'b1;
        repeat (4) @(negedge clk);
        chk_state("R12 held in G3", 3);
        batt_low = 1'b0;
        @(negedge clk);
        chk_state("R12 resumes after release", 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule